// File: doc/BRIEF.md
# Two-Share Masked Key Parity Unit

This block returns the single-bit GF(2) inner product of a challenge word with a secret key. The key is never stored as a plain value. It is held as two Boolean shares, and the key is the XOR of those shares. Because the inner product is linear over XOR, each share gets its own datapath. Each datapath ANDs the challenge with its share, reduces the result to one parity bit and registers it. The two registered share parities meet in one XOR gate, and that XOR is registered as the result. No gate anywhere combines bits of the two shares before that point.

The host loads both shares together through two separate ports. It can rerandomize them at any time by pulsing a refresh strobe with a fresh mask. The same mask is XORed into both shares in one cycle, so the represented key does not change.

A challenge presented in a cycle where the shares are being written is held back for one cycle. It is then evaluated against the updated shares. Challenges that arrive while a held one is waiting follow it through the same one-cycle delay, so results always come out in order.

Top module: `shared_key_parity`

## Requirements
- R1: When resultValid is high, resultBit equals the XOR over all bit positions of chalData AND (shareA XOR shareB), using the challenge that produced the result and the shares in force when it was evaluated.
- R2: A challenge presented while loadEn and refreshEn are both low, and while no earlier challenge is waiting in the delay stage, has its resultValid high exactly two clock cycles later. Back-to-back challenges give back-to-back results. resultValid is low in every cycle with no result due.
- R3: A challenge presented in a cycle where loadEn or refreshEn is high has its resultValid high exactly three cycles later. Its result reflects the shares after that cycle's update.
- R4: A refresh (refreshEn high, loadEn low) XORs refreshMask into both shares in the same cycle. Every later result is the same as it would have been with no refresh.
- R5: loadEn writes loadShareA and loadShareB into the two shares in one cycle. If refreshEn is high in the same cycle, the load takes priority. Later results follow the key loadShareA XOR loadShareB.
- R6: Reset (rst_n low, asynchronous) clears both shares to zero and drives resultValid low. A challenge after reset with no load yields resultBit 0.
- R7: A challenge arriving while a delayed challenge is waiting is itself delayed one cycle, whether or not an update is active. No challenge is lost or reordered, and the path returns to two-cycle latency after the first cycle with no challenge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Write both key shares this cycle |
| loadShareA | input | KEY_W | New value of share A |
| loadShareB | input | KEY_W | New value of share B |
| refreshEn | input | 1 | XOR refreshMask into both shares this cycle |
| refreshMask | input | KEY_W | Fresh random mask for the refresh |
| chalValid | input | 1 | chalData carries a challenge this cycle |
| chalData | input | KEY_W | Challenge word |
| resultValid | output | 1 | resultBit carries a result this cycle |
| resultBit | output | 1 | Inner product of challenge and recombined key |

## Verification
The bench first applies the zero challenge, the all-ones challenge and walking single-bit challenges against a loaded key. The zero challenge separates a stuck-high output, all-ones exposes the full key parity, and each single-bit challenge isolates one key bit, so a dropped lane bit or a swapped share shows up. It then places challenges in the same cycle as a refresh or a load, and also directly behind such a cycle. These cases tell apart a correct one-cycle hold from a lost challenge, an early result computed with stale shares, and reordered results. A long random run mixes loads, refreshes with random masks and challenges. It shows that the recombined key survives refresh: a refresh applied to only one share, or with different masks per share, flips about half of the later results.

// File: rtl/skp_pkg.sv
package skp_pkg;

  localparam int SHARE_COUNT = 2;

  typedef struct packed {
    logic issue;          // evaluate a challenge against the shares this cycle
    logic selHold;        // evaluated challenge comes from the delay register
    logic captureHold;    // park the incoming challenge for one cycle
    logic loadShares;     // overwrite both shares
    logic refreshShares;  // XOR the mask into both shares
    logic retire;         // share parities are valid, combine them
  } skp_strobe_t;

endpackage

// File: rtl/skp_parity_tree.sv
module skp_parity_tree #(
  parameter int IN_W = 64
) (
  input  logic [IN_W-1:0] dataIn,
  output logic            parityOut
);

  localparam int LEVELS = (IN_W > 1) ? $clog2(IN_W) : 0;
  localparam int LEAVES = 1 << LEVELS;

  // Heap-ordered tree: node j has children 2j and 2j+1, leaves at LEAVES..2*LEAVES-1.
  logic [2*LEAVES-1:1] node;
  logic [LEAVES-1:0]   padded;

  assign padded = LEAVES'(dataIn);

  genvar gi;
  generate
    for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
      assign node[LEAVES + gi] = padded[gi];
    end
    for (gi = 1; gi < LEAVES; gi++) begin : g_inner
      assign node[gi] = node[2*gi] ^ node[2*gi + 1];
    end
  endgenerate

  assign parityOut = node[1];

endmodule

// File: rtl/skp_share_lane.sv
module skp_share_lane #(
  parameter int KEY_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loadEn,
  input  logic [KEY_W-1:0] loadValue,
  input  logic             refreshEn,
  input  logic [KEY_W-1:0] refreshMask,
  input  logic             issue,
  input  logic [KEY_W-1:0] chalData,
  output logic [KEY_W-1:0] shareQ,
  output logic             parityQ
);

  logic [KEY_W-1:0] masked;
  logic             parityNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shareQ <= '0;
    end else if (loadEn) begin
      shareQ <= loadValue;
    end else if (refreshEn) begin
      shareQ <= shareQ ^ refreshMask;
    end
  end

  assign masked = chalData & shareQ;

  skp_parity_tree #(.IN_W(KEY_W)) tree_i (
    .dataIn    (masked),
    .parityOut (parityNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parityQ <= 1'b0;
    end else if (issue) begin
      parityQ <= parityNext;
    end
  end

endmodule

// File: rtl/skp_ctrl.sv
module skp_ctrl
  import skp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loadEn,
  input  logic        refreshEn,
  input  logic        chalValid,
  output skp_strobe_t strobe,
  output logic        resultValid
);

  logic holdValid;
  logic parValid;
  logic resValid;
  logic updateNow;

  assign updateNow = loadEn | refreshEn;

  always_comb begin
    strobe               = '0;
    strobe.selHold       = holdValid;
    strobe.issue         = holdValid | (chalValid & ~updateNow);
    strobe.captureHold   = chalValid & (updateNow | holdValid);
    strobe.loadShares    = loadEn;
    strobe.refreshShares = refreshEn & ~loadEn;
    strobe.retire        = parValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdValid <= 1'b0;
      parValid  <= 1'b0;
      resValid  <= 1'b0;
    end else begin
      holdValid <= strobe.captureHold;
      parValid  <= strobe.issue;
      resValid  <= parValid;
    end
  end

  assign resultValid = resValid;

endmodule

// File: rtl/skp_datapath.sv
module skp_datapath
  import skp_pkg::*;
#(
  parameter int KEY_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  skp_strobe_t      strobe,
  input  logic [KEY_W-1:0] loadShareA,
  input  logic [KEY_W-1:0] loadShareB,
  input  logic [KEY_W-1:0] refreshMask,
  input  logic [KEY_W-1:0] chalData,
  output logic [KEY_W-1:0] shareAView,
  output logic [KEY_W-1:0] shareBView,
  output logic             resultBit
);

  logic [KEY_W-1:0]       holdData;
  logic [KEY_W-1:0]       issueData;
  logic [KEY_W-1:0]       loadVal  [SHARE_COUNT];
  logic [KEY_W-1:0]       shareVal [SHARE_COUNT];
  logic [SHARE_COUNT-1:0] laneParity;
  logic                   resultQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdData <= '0;
    end else if (strobe.captureHold) begin
      holdData <= chalData;
    end
  end

  assign issueData  = strobe.selHold ? holdData : chalData;
  assign loadVal[0] = loadShareA;
  assign loadVal[1] = loadShareB;

  genvar gs;
  generate
    for (gs = 0; gs < SHARE_COUNT; gs++) begin : g_lane
      skp_share_lane #(.KEY_W(KEY_W)) lane_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .loadEn      (strobe.loadShares),
        .loadValue   (loadVal[gs]),
        .refreshEn   (strobe.refreshShares),
        .refreshMask (refreshMask),
        .issue       (strobe.issue),
        .chalData    (issueData),
        .shareQ      (shareVal[gs]),
        .parityQ     (laneParity[gs])
      );
    end
  endgenerate

  // Only the registered one-bit share parities are ever combined.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultQ <= 1'b0;
    end else if (strobe.retire) begin
      resultQ <= ^laneParity;
    end
  end

  assign shareAView = shareVal[0];
  assign shareBView = shareVal[1];
  assign resultBit  = resultQ;

endmodule

// File: rtl/shared_key_parity.sv
module shared_key_parity
  import skp_pkg::*;
#(
  parameter int KEY_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loadEn,
  input  logic [KEY_W-1:0] loadShareA,
  input  logic [KEY_W-1:0] loadShareB,
  input  logic             refreshEn,
  input  logic [KEY_W-1:0] refreshMask,
  input  logic             chalValid,
  input  logic [KEY_W-1:0] chalData,
  output logic             resultValid,
  output logic             resultBit
);

  skp_strobe_t      strobe;
  logic [KEY_W-1:0] shareAView;
  logic [KEY_W-1:0] shareBView;

  skp_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .loadEn      (loadEn),
    .refreshEn   (refreshEn),
    .chalValid   (chalValid),
    .strobe      (strobe),
    .resultValid (resultValid)
  );

  skp_datapath #(.KEY_W(KEY_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .loadShareA  (loadShareA),
    .loadShareB  (loadShareB),
    .refreshMask (refreshMask),
    .chalData    (chalData),
    .shareAView  (shareAView),
    .shareBView  (shareBView),
    .resultBit   (resultBit)
  );

endmodule

// File: rtl/skp_checker.sv
module skp_checker #(
  parameter int KEY_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             loadEn,
  input logic [KEY_W-1:0] loadShareA,
  input logic [KEY_W-1:0] loadShareB,
  input logic             refreshEn,
  input logic [KEY_W-1:0] refreshMask,
  input logic             chalValid,
  input logic             issue,
  input logic             selHold,
  input logic [KEY_W-1:0] shareAView,
  input logic [KEY_W-1:0] shareBView,
  input logic             resultValid
);

  // R2: an evaluated challenge yields a result two cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> ##2 resultValid);

  // R2: no result without an evaluation two cycles earlier
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> $past(issue, 2));

  // R3: a challenge meeting an update is parked
  a_r3_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (chalValid && (loadEn || refreshEn)) |=> selHold);

  // R3: nothing is evaluated from the input while shares change
  a_r3_no_eval_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    ((loadEn || refreshEn) && !selHold) |-> !issue);

  // R4: refresh keeps the recombined key
  a_r4_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (refreshEn && !loadEn) |=> ((shareAView ^ shareBView) == $past(shareAView ^ shareBView)));

  // R4: refresh applies the mask to share A
  a_r4_mask_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (refreshEn && !loadEn) |=> (shareAView == $past(shareAView ^ refreshMask)));

  // R5: load writes both shares in one cycle
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    loadEn |=> (shareAView == $past(loadShareA) && shareBView == $past(loadShareB)));

  // R7: a challenge behind a parked one is parked too
  a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (selHold && chalValid) |=> selHold);

  // R6: reset state
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r6_reset_clear: assert (shareAView == '0 && shareBView == '0 && !resultValid);
    end
  end

endmodule

bind shared_key_parity skp_checker #(.KEY_W(KEY_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .loadEn      (loadEn),
  .loadShareA  (loadShareA),
  .loadShareB  (loadShareB),
  .refreshEn   (refreshEn),
  .refreshMask (refreshMask),
  .chalValid   (chalValid),
  .issue       (strobe.issue),
  .selHold     (strobe.selHold),
  .shareAView  (shareAView),
  .shareBView  (shareBView),
  .resultValid (resultValid)
);

// File: tb/shared_key_parity_tb_top.sv
`timescale 1ns/1ps
module shared_key_parity_tb_top;

  localparam int KW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loadEn = 1'b0;
  logic [KW-1:0] loadShareA = '0;
  logic [KW-1:0] loadShareB = '0;
  logic          refreshEn = 1'b0;
  logic [KW-1:0] refreshMask = '0;
  logic          chalValid = 1'b0;
  logic [KW-1:0] chalData = '0;
  logic          resultValid;
  logic          resultBit;

  always #2 clk = ~clk;

  shared_key_parity #(.KEY_W(KW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .loadEn      (loadEn),
    .loadShareA  (loadShareA),
    .loadShareB  (loadShareB),
    .refreshEn   (refreshEn),
    .refreshMask (refreshMask),
    .chalValid   (chalValid),
    .chalData    (chalData),
    .resultValid (resultValid),
    .resultBit   (resultBit)
  );

  typedef struct {
    bit    expBit;
    int    due;
    string tag;
  } exp_t;

  exp_t          expQ[$];
  exp_t          head;
  int            cyc = 0;
  int            nRun = 0;
  int            nFail = 0;
  bit            prevDelayed = 0;
  bit            done = 0;
  logic [KW-1:0] keyModel = '0;

  function automatic logic [KW-1:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  // Result monitor: compares value and arrival cycle of every result.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (resultValid) begin
        nRun++;
        if (expQ.size() == 0) begin
          nFail++;
          $display("FAIL R2 unexpected resultValid actual=1 expected=0 at cycle %0d", cyc);
        end else begin
          head = expQ.pop_front();
          if (resultBit !== head.expBit || cyc != head.due) begin
            nFail++;
            $display("FAIL %s result actual=%0b@%0d expected=%0b@%0d",
                     head.tag, resultBit, cyc, head.expBit, head.due);
          end
        end
      end else if (expQ.size() > 0 && cyc >= expQ[0].due) begin
        nRun++;
        nFail++;
        head = expQ.pop_front();
        $display("FAIL %s missing result actual=valid0@%0d expected=valid1@%0d",
                 head.tag, cyc, head.due);
      end
    end
  end

  // One cycle of stimulus plus the reference model (R1, R3, R5, R7 rules).
  task automatic drive(input bit ld, input logic [KW-1:0] a, input logic [KW-1:0] b,
                       input bit rf, input logic [KW-1:0] m,
                       input bit cv, input logic [KW-1:0] x, input string tag);
    bit upd;
    bit del;
    @(posedge clk); #1;
    loadEn = ld; loadShareA = a; loadShareB = b;
    refreshEn = rf; refreshMask = m;
    chalValid = cv; chalData = x;
    upd = ld || rf;
    del = cv && (upd || prevDelayed);
    prevDelayed = del;
    if (ld) keyModel = a ^ b;
    if (cv) expQ.push_back('{^(x & keyModel), cyc + (del ? 4 : 3), tag});
  endtask

  task automatic idle();
    drive(0, '0, '0, 0, '0, 0, '0, "");
  endtask

  task automatic chal(input logic [KW-1:0] x, input string tag);
    drive(0, '0, '0, 0, '0, 1, x, tag);
  endtask

  task automatic drain(input string tag);
    repeat (6) idle();
    nRun++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL %s pending results actual=%0d expected=0", tag, expQ.size());
      expQ.delete();
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    nRun++;
    if (resultValid !== 1'b0) begin
      nFail++;
      $display("FAIL R6 resultValid in reset actual=%0b expected=0", resultValid);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    chal('1, "R6");
    chal(64'h8000_0000_0000_0001, "R6");
    drain("R6");
  endtask

  task automatic t_basic();
    drive(1, 64'hA5A5_0F0F_1234_5678, 64'h0FF0_3C3C_9ABC_DEF1, 0, '0, 0, '0, "R5");
    chal('0, "R1");
    chal('1, "R1");
    chal(64'h5555_5555_5555_5555, "R1");
    for (int i = 0; i < KW; i += 7) chal(64'd1 << i, "R1");
    idle();
    chal(64'd1 << (KW - 1), "R2");
    drain("R2");
  endtask

  task automatic t_refresh();
    logic [KW-1:0] x;
    drive(1, rnd(), rnd(), 0, '0, 0, '0, "R5");
    for (int i = 0; i < 4; i++) begin
      x = rnd();
      chal(x, "R4");
      drive(0, '0, '0, 1, rnd(), 0, '0, "R4");
      chal(x, "R4");
    end
    drain("R4");
  endtask

  task automatic t_stall();
    drive(1, rnd(), rnd(), 0, '0, 0, '0, "R5");
    drive(0, '0, '0, 1, rnd(), 1, rnd(), "R3");
    idle();
    drive(1, rnd(), rnd(), 0, '0, 1, '1, "R3");
    idle();
    drive(1, rnd(), rnd(), 1, rnd(), 1, rnd(), "R5");
    drain("R3");
  endtask

  task automatic t_burst();
    drive(1, rnd(), rnd(), 0, '0, 0, '0, "R5");
    drive(0, '0, '0, 1, rnd(), 1, rnd(), "R7");
    chal(rnd(), "R7");
    chal(rnd(), "R7");
    drive(1, rnd(), rnd(), 0, '0, 1, rnd(), "R7");
    chal(rnd(), "R7");
    idle();
    chal(rnd(), "R7");
    drain("R7");
  endtask

  task automatic t_random();
    int act;
    for (int i = 0; i < 400; i++) begin
      act = $urandom_range(0, 9);
      drive(act == 0, rnd(), rnd(), act inside {1, 2}, rnd(), act >= 2, rnd(), "R1");
    end
    drain("R1");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_refresh();
    t_stall();
    t_burst();
    t_random();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule